// File: doc/BRIEF.md
# APB Level Interrupt Aggregator

This block collects up to 64 level-sensitive interrupt lines and merges them into one request for a parent interrupt controller. Software reaches it through an APB slave port. Each source has two independent control bits: a permit bit that admits the line, and a veto bit that blocks it. A read-only summary word per bank reports which lines are live, permitted and not vetoed at that moment.

Sources are split into two 32-bit banks. The low bank holds lines 0 to 31 and the high bank holds lines 32 to 63. The number of lines that are built is a parameter. Control storage exists only for lines that are built, so a driver can learn the line count by writing all ones to the permit words and reading them back. The summary tracks the input levels directly, and clearing a request is done at the source.

Top module: `irq_agg_apb`

## Requirements
- R1: Word offsets: permit low 0x00, permit high 0x04, veto low 0x08, veto high 0x0c, summary low 0x30, summary high 0x34. Bit i of a high-bank word belongs to source 32+i.
- R2: Permit and veto bits of sources at index NUM_SRC or above are not stored and always read 0, including right after all ones has been written to them.
- R3: A veto bit of 1 removes its source from the summary and a veto bit of 0 passes it. Summary bit n is 1 exactly when input n is high, permit bit n is 1 and veto bit n is 0.
- R4: A source whose permit bit is 0 never shows in the summary, whatever its veto bit holds.
- R5: The summary follows the live input level in the same cycle. Reading the summary clears nothing.
- R6: irq_o is the OR of all summary bits, registered. It changes on the first rising clock edge after the inputs or control bits change.
- R7: Every APB access completes with no wait states (pready_o is 1), and pslverr_o is always 0.
- R8: Reads of unmapped offsets return 0. Writes to unmapped offsets or to either summary word change no stored bit.
- R9: Writing a veto word leaves every permit bit unchanged, and writing a permit word leaves every veto bit unchanged.
- R10: After reset, every permit bit, every veto bit and irq_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write when 1 |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready, always 1 |
| pslverr_o | output | 1 | APB error, always 0 |
| irq_src_i | input | NUM_SRC | Level-sensitive interrupt inputs |
| irq_o | output | 1 | Registered combined request to the parent |

## Verification
The bench builds the block with NUM_SRC set to 37, so the high bank is only partly built. With that value, probing the line count produces a read-back of 0x1f, and the bench can check that vetoing and permitting sources in the high bank stops at bit 4. The low bank is fully built, so full-word patterns there exercise the per-bit gating. Because the two banks decode to different words, the bench can also confirm that writes to one bank do not spill into the other.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned BANK_W = 32;
  localparam int unsigned BANKS  = 2;
  localparam int unsigned SLOTS  = BANK_W * BANKS;

  // word indices (byte offset / 4) of bank 0; bank 1 is the next word
  localparam logic [5:0] WORD_PERMIT = 6'h00;
  localparam logic [5:0] WORD_VETO   = 6'h02;
  localparam logic [5:0] WORD_SUMM   = 6'h0c;

  typedef enum logic [1:0] {
    KIND_NONE,
    KIND_PERMIT,
    KIND_VETO,
    KIND_SUMM
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e kind;
    logic      bank;
  } reg_sel_t;

  function automatic reg_sel_t decode_word(input logic [5:0] word, input logic in_range);
    reg_sel_t s;
    s.bank = word[0];
    s.kind = KIND_NONE;
    if (in_range) begin
      unique case ({word[5:1], 1'b0})
        WORD_PERMIT: s.kind = KIND_PERMIT;
        WORD_VETO:   s.kind = KIND_VETO;
        WORD_SUMM:   s.kind = KIND_SUMM;
        default:     s.kind = KIND_NONE;
      endcase
    end
    return s;
  endfunction
endpackage

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 37
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  reg_sel_t          sel_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [SLOTS-1:0]  permit_o,
  output logic [SLOTS-1:0]  veto_o
);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic hit_permit, hit_veto;
    assign hit_permit = wr_i && (sel_i.kind == KIND_PERMIT) && (sel_i.bank == 1'(b));
    assign hit_veto   = wr_i && (sel_i.kind == KIND_VETO)   && (sel_i.bank == 1'(b));

    for (genvar i = 0; i < BANK_W; i++) begin : g_bit
      localparam int unsigned IDX = b * BANK_W + i;
      if (IDX < NUM_SRC) begin : g_flop
        logic permit_q, veto_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) begin
            permit_q <= 1'b0;
            veto_q   <= 1'b0;
          end else begin
            if (hit_permit) permit_q <= wdata_i[i];
            if (hit_veto)   veto_q   <= wdata_i[i];
          end
        end
        assign permit_o[IDX] = permit_q;
        assign veto_o[IDX]   = veto_q;
      end else begin : g_trim
        assign permit_o[IDX] = 1'b0;
        assign veto_o[IDX]   = 1'b0;
      end
    end
  end

  // R9: a veto write leaves permits untouched
  p_veto_keeps_permit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i.kind == KIND_VETO) |=> $stable(permit_o));

  // R8: writes to summary or unmapped words store nothing
  p_dead_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (sel_i.kind == KIND_SUMM || sel_i.kind == KIND_NONE))
      |=> ($stable(permit_o) && $stable(veto_o)));

endmodule

// File: rtl/irq_agg_gate.sv
module irq_agg_gate
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 37
) (
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [SLOTS-1:0]   permit_i,
  input  logic [SLOTS-1:0]   veto_i,
  output logic [SLOTS-1:0]   summ_o
);

  for (genvar n = 0; n < SLOTS; n++) begin : g_slot
    if (n < NUM_SRC) begin : g_live
      assign summ_o[n] = src_i[n] & permit_i[n] & ~veto_i[n];
    end else begin : g_dead
      assign summ_o[n] = 1'b0;
    end
  end

endmodule

// File: rtl/irq_agg_combine.sv
module irq_agg_combine
  import irq_agg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SLOTS-1:0] summ_i,
  output logic             irq_o
);

  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |summ_i;
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/irq_agg_apb.sv
module irq_agg_apb
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_SRC = 37,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               psel_i,
  input  logic               penable_i,
  input  logic               pwrite_i,
  input  logic [ADDR_W-1:0]  paddr_i,
  input  logic [BANK_W-1:0]  pwdata_i,
  output logic [BANK_W-1:0]  prdata_o,
  output logic               pready_o,
  output logic               pslverr_o,
  input  logic [NUM_SRC-1:0] irq_src_i,
  output logic               irq_o
);

  logic             in_range;
  reg_sel_t         sel;
  logic             wr;
  logic [SLOTS-1:0] permit, veto, summ;

  if (ADDR_W > 8) begin : g_hi_addr
    assign in_range = ~|paddr_i[ADDR_W-1:8];
  end else begin : g_lo_addr
    assign in_range = 1'b1;
  end

  assign sel       = decode_word(paddr_i[7:2], in_range);
  assign wr        = psel_i && penable_i && pwrite_i;
  assign pready_o  = 1'b1;
  assign pslverr_o = 1'b0;

  irq_agg_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr),
    .sel_i    (sel),
    .wdata_i  (pwdata_i),
    .permit_o (permit),
    .veto_o   (veto)
  );

  irq_agg_gate #(.NUM_SRC(NUM_SRC)) u_gate (
    .src_i    (irq_src_i),
    .permit_i (permit),
    .veto_i   (veto),
    .summ_o   (summ)
  );

  irq_agg_combine u_comb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .summ_i (summ),
    .irq_o  (irq_o)
  );

  always_comb begin
    unique case (sel.kind)
      KIND_PERMIT: prdata_o = sel.bank ? permit[SLOTS-1:BANK_W] : permit[BANK_W-1:0];
      KIND_VETO:   prdata_o = sel.bank ? veto[SLOTS-1:BANK_W]   : veto[BANK_W-1:0];
      KIND_SUMM:   prdata_o = sel.bank ? summ[SLOTS-1:BANK_W]   : summ[BANK_W-1:0];
      default:     prdata_o = '0;
    endcase
  end

  // R4: unpermitted lines never reach the summary
  p_unpermitted_absent_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~permit) & summ) == '0);

  // R3: all-vetoed leaves the summary empty
  p_full_veto_empty_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&veto[NUM_SRC-1:0]) |-> (summ == '0));

  // R6: with nothing permitted the request is low one clock later
  p_no_permit_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (permit == '0) |=> !irq_o);

endmodule

// File: tb/irq_agg_apb_test.sv
`timescale 1ns/1ps
module irq_agg_apb_test;
  localparam int N = 37;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [N-1:0] src = '0;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_agg_apb #(.NUM_SRC(N), .ADDR_W(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .pready_o(pready), .pslverr_o(pslverr), .irq_src_i(src), .irq_o(irq)
  );

  // behavioural reference
  localparam logic [63:0] BUILT = (64'd1 << N) - 64'd1;
  logic [63:0] m_permit = '0, m_veto = '0;
  logic        m_irq = 1'b0;

  function automatic logic [63:0] m_summ();
    return ({{(64-N){1'b0}}, src} & m_permit & ~m_veto);
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return m_permit[31:0];
      8'h04: return m_permit[63:32];
      8'h08: return m_veto[31:0];
      8'h0c: return m_veto[63:32];
      8'h30: return m_summ() >> 0;
      8'h34: return 32'(m_summ() >> 32);
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_permit <= '0; m_veto <= '0; m_irq <= 1'b0;
    end else begin
      m_irq <= (m_summ() != 64'h0);
      if (psel && penable && pwrite) begin
        case (paddr)
          8'h00: m_permit[31:0]  <= pwdata & BUILT[31:0];
          8'h04: m_permit[63:32] <= pwdata & BUILT[63:32];
          8'h08: m_veto[31:0]    <= pwdata & BUILT[31:0];
          8'h0c: m_veto[63:32]   <= pwdata & BUILT[63:32];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle compare of the registered request (R6)
  always @(negedge clk) begin
    if (rst_n && !done) chk(irq === m_irq, "R6 irq_o vs model", 64'(irq), 64'(m_irq));
  end

  task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    #1 chk(pready === 1'b1 && pslverr === 1'b0, "R7 write handshake", 64'({pready, pslverr}), 64'h2);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_read(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1;
    chk(prdata === exp, req, 64'(prdata), 64'(exp));
    chk(prdata === m_read(a), {req, " model"}, 64'(prdata), 64'(m_read(a)));
    chk(pready === 1'b1 && pslverr === 1'b0, "R7 read handshake", 64'({pready, pslverr}), 64'h2);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 / R1: reset state
    chk(irq === 1'b0, "R10 irq after reset", 64'(irq), 64'h0);
    apb_read(8'h00, 32'h0, "R10 permit lo reset");
    apb_read(8'h04, 32'h0, "R10 permit hi reset");
    apb_read(8'h08, 32'h0, "R10 veto lo reset");
    apb_read(8'h0c, 32'h0, "R10 veto hi reset");
    apb_read(8'h30, 32'h0, "R1 summary lo reset");
    apb_read(8'h34, 32'h0, "R1 summary hi reset");

    // R2: probe the line count
    apb_write(8'h00, 32'hffff_ffff);
    apb_write(8'h04, 32'hffff_ffff);
    apb_read(8'h00, 32'hffff_ffff, "R2 permit lo probe");
    apb_read(8'h04, 32'h0000_001f, "R2 permit hi probe");

    // R3: all lines high, nothing vetoed
    src = '1;
    apb_read(8'h30, 32'hffff_ffff, "R3 summary lo open");
    apb_read(8'h34, 32'h0000_001f, "R3 summary hi open");
    chk(irq === 1'b1, "R6 irq with open lines", 64'(irq), 64'h1);

    // R3/R2/R9: full veto
    apb_write(8'h08, 32'hffff_ffff);
    apb_write(8'h0c, 32'hffff_ffff);
    apb_read(8'h0c, 32'h0000_001f, "R2 veto hi trimmed");
    apb_read(8'h30, 32'h0, "R3 summary lo vetoed");
    apb_read(8'h34, 32'h0, "R3 summary hi vetoed");
    apb_read(8'h00, 32'hffff_ffff, "R9 permit lo kept");
    apb_read(8'h04, 32'h0000_001f, "R9 permit hi kept");
    chk(irq === 1'b0, "R6 irq all vetoed", 64'(irq), 64'h0);

    // R3: partial veto in the low bank
    apb_write(8'h08, 32'h0000_ff00);
    apb_read(8'h30, 32'hffff_00ff, "R3 summary lo partial veto");

    // R4: permit gating regardless of veto
    apb_write(8'h00, 32'h0f0f_0f0f);
    apb_write(8'h08, 32'h0);
    apb_read(8'h30, 32'h0f0f_0f0f, "R4 summary lo permit pattern");
    apb_read(8'h08, 32'h0, "R9 veto lo after permit write");
    apb_write(8'h04, 32'h0);
    apb_write(8'h0c, 32'h0);
    apb_read(8'h34, 32'h0, "R4 summary hi unpermitted");

    // R5: level following, read without clear
    apb_write(8'h00, 32'hffff_ffff);
    apb_write(8'h04, 32'hffff_ffff);
    @(negedge clk);
    src = 37'h10_0000_0001;
    apb_read(8'h30, 32'h0000_0001, "R5 summary lo level");
    apb_read(8'h30, 32'h0000_0001, "R5 summary lo reread");
    apb_read(8'h34, 32'h0000_0010, "R5 summary hi level");
    apb_read(8'h34, 32'h0000_0010, "R5 summary hi reread");
    @(negedge clk);
    src = '0;
    #1 chk(irq === 1'b1, "R6 irq holds before edge", 64'(irq), 64'h1);
    apb_read(8'h30, 32'h0, "R5 summary lo drops");
    chk(irq === 1'b0, "R6 irq dropped", 64'(irq), 64'h0);

    // R6: one-clock lag on rise
    @(negedge clk);
    src[3] = 1'b1;
    #1 chk(irq === 1'b0, "R6 irq before edge", 64'(irq), 64'h0);
    @(negedge clk);
    chk(irq === 1'b1, "R6 irq after edge", 64'(irq), 64'h1);

    // R8: unmapped and summary writes
    apb_write(8'h10, 32'hffff_ffff);
    apb_write(8'h30, 32'h0);
    apb_write(8'h34, 32'h0);
    apb_read(8'h10, 32'h0, "R8 unmapped read 0x10");
    apb_read(8'h20, 32'h0, "R8 unmapped read 0x20");
    apb_read(8'h08, 32'h0, "R8 veto lo unchanged");
    apb_read(8'h0c, 32'h0, "R8 veto hi unchanged");
    apb_read(8'h00, 32'hffff_ffff, "R8 permit lo unchanged");
    apb_read(8'h30, 32'h0000_0008, "R8 summary lo unchanged");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule